// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This unit holds the pending-event flags and the per-source enables for one timer with three interrupt sources: the overflow event, compare channel A and compare channel B. The timer logic sends a one-cycle pulse for each event, and that pulse sets the matching flag. Software sees two byte-wide registers on a small register bus. One register holds the enables and the other holds the flags. A 1-bit address selects between them for both reads and writes.

A flag clears in one of two ways. Software can write a one to that flag's bit, or the interrupt controller can acknowledge the vector for that source, which is a valid strobe with a 2-bit source index. A source raises its request line only when three things are all true: its flag is set, its enable is set, and the core's global interrupt enable input is high. The three request lines are also ORed into one combined request, which is registered so that it cannot glitch.

Top module: `tmr_irq_unit`

## Requirements
- R1: Synchronous reset clears every enable bit, every flag bit and `irq_any`. Both registers then read 0x00 and `irq_src` is 0.
- R2: A write with `reg_addr`=0 stores `reg_wdata[2:0]` as the enables. A read with `reg_addr`=0 returns them in bits 2:0, and bits 7:3 read zero whatever was written.
- R3: In both registers, bit 0 is overflow, bit 1 is compare A and bit 2 is compare B. `evt[i]` high for one cycle sets flag bit i at that clock edge. Other flags are unchanged, and a flag never sets without its event.
- R4: A write with `reg_addr`=1 clears each flag whose `reg_wdata` bit is one and leaves flags under zero bits unchanged. A read with `reg_addr`=1 returns the flags in bits 2:0, and bits 7:3 read zero.
- R5: `ack_valid` with `ack_idx` = i (0, 1 or 2) clears only flag bit i. `ack_idx` = 3 clears nothing, and `ack_idx` has no effect while `ack_valid` is low.
- R6: If an event and a clear of the same flag arrive in the same cycle, whether the clear comes from a write, an acknowledge or both, the flag ends at one.
- R7: `irq_src[i]` is combinationally `gie` AND enable bit i AND flag bit i.
- R8: `irq_any` equals the OR of `irq_src` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = enables, 1 = flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| evt | input | 3 | Event pulses: bit 0 overflow, bit 1 compare A, bit 2 compare B |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_idx | input | 2 | Index of the acknowledged source |
| gie | input | 1 | Global interrupt enable |
| irq_src | output | 3 | Per-source request lines |
| irq_any | output | 1 | Registered OR of the request lines |

## Verification
The bench builds the unit with its package defaults: three sources, an 8-bit register width and a 2-bit acknowledge index. With so few sources, every state can be reached. The bench sweeps all eight enable patterns against all eight flag patterns with the global enable both off and on. It also tries every clearing write pattern against every starting flag state, and every acknowledge index, including the unused index 3, against every flag state. Set-versus-clear collisions are checked for each source.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int unsigned REG_W = 8;
    localparam int unsigned NSRC  = 3;
    localparam int unsigned IDX_W = $clog2(NSRC + 1);

    localparam int unsigned SRC_OVF  = 0;
    localparam int unsigned SRC_CMPA = 1;
    localparam int unsigned SRC_CMPB = 2;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_FLAG   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic            we;
        reg_sel_e        sel;
        logic [NSRC-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } ack_req_t;

    // One-hot select for an acknowledge index; out-of-range indices give zero.
    function automatic logic [NSRC-1:0] idx_to_sel(input logic [IDX_W-1:0] idx);
        logic [NSRC-1:0] sel;
        for (int i = 0; i < NSRC; i++) begin
            sel[i] = (idx == IDX_W'(i));
        end
        return sel;
    endfunction

    function automatic logic [REG_W-1:0] pad_reg(input logic [NSRC-1:0] v);
        return {{(REG_W-NSRC){1'b0}}, v};
    endfunction
endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         wr,
    output logic [NSRC-1:0] enable_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (wr.we && wr.sel == SEL_ENABLE) begin
            enable_q <= wr.data;
        end
    end
endmodule

// File: rtl/irq_clear_decode.sv
module irq_clear_decode
    import tmr_irq_pkg::*;
(
    input  wr_req_t         wr,
    input  ack_req_t        ack,
    output logic [NSRC-1:0] clr
);
    logic [NSRC-1:0] clr_sw;
    logic [NSRC-1:0] clr_hw;

    always_comb begin
        clr_sw = (wr.we && wr.sel == SEL_FLAG) ? wr.data : '0;
        clr_hw = ack.valid ? idx_to_sel(ack.idx) : '0;
        clr    = clr_sw | clr_hw;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] flag_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (set[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_req_combine.sv
module irq_req_combine
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            gie,
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] enable,
    output logic [NSRC-1:0] req,
    output logic            any_q
);
    always_comb begin
        req = flag & enable & {NSRC{gie}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            any_q <= 1'b0;
        end else begin
            any_q <= |req;
        end
    end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]  evt,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic             gie,
    output logic [NSRC-1:0]  irq_src,
    output logic             irq_any
);
    wr_req_t         wr;
    ack_req_t        ack;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] mask_q;

    always_comb begin
        wr.we   = reg_we;
        wr.sel  = reg_sel_e'(reg_addr);
        wr.data = reg_wdata[NSRC-1:0];
        ack.valid = ack_valid;
        ack.idx   = ack_idx;
    end

    irq_enable_bank u_enable (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .enable_q (mask_q)
    );

    irq_clear_decode u_clear (
        .wr  (wr),
        .ack (ack),
        .clr (clr)
    );

    irq_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set    (evt),
        .clr    (clr),
        .flag_q (flag_q)
    );

    irq_req_combine u_req (
        .clk    (clk),
        .rst    (rst),
        .gie    (gie),
        .flag   (flag_q),
        .enable (mask_q),
        .req    (irq_src),
        .any_q  (irq_any)
    );

    always_comb begin
        reg_rdata = (reg_sel_e'(reg_addr) == SEL_FLAG) ? pad_reg(flag_q) : pad_reg(mask_q);
    end
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk
    import tmr_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [NSRC-1:0]  evt,
    input logic             ack_valid,
    input logic [IDX_W-1:0] ack_idx,
    input logic             gie,
    input logic [NSRC-1:0]  irq_src,
    input logic             irq_any,
    input logic [NSRC-1:0]  flag_q,
    input logic [NSRC-1:0]  mask_q
);
    logic [NSRC-1:0] ack_sel;
    always_comb begin
        ack_sel = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (ack_valid && ack_idx == IDX_W'(i)) ack_sel[i] = 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (flag_q == '0 && mask_q == '0 && !irq_any));

    a_r2_rsvd_read_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:NSRC] == '0);

    a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_addr) |=> mask_q == $past(reg_wdata[NSRC-1:0]));

    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));

    a_r3_only_events_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt)) == '0));

    a_r5_ack_scope: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !reg_we) |=>
            (((flag_q ^ $past(flag_q)) & ~$past(ack_sel) & ~$past(evt)) == '0));

    a_r7_needs_flag_and_enable: assert property (@(posedge clk) disable iff (rst)
        (irq_src & ~(flag_q & mask_q)) == '0);

    a_r7_needs_gie: assert property (@(posedge clk) disable iff (rst)
        !gie |-> irq_src == '0);

    a_r8_any_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_any == $past(|irq_src));
endmodule

bind tmr_irq_unit tmr_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt       (evt),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .gie       (gie),
    .irq_src   (irq_src),
    .irq_any   (irq_any),
    .flag_q    (flag_q),
    .mask_q    (mask_q)
);

// File: tb/tb_tmr_irq_unit.sv
`timescale 1ns/1ps
module tb_tmr_irq_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] evt = '0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_idx = '0;
    logic       gie = 1'b0;
    logic [2:0] irq_src;
    logic       irq_any;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_irq_unit dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .gie(gie),
        .irq_src(irq_src), .irq_any(irq_any)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic load_flags(input logic [2:0] p);
        wr(1'b1, 8'hFF);
        evt = p;
        tick();
        evt = '0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R1: reset state
        rd(1'b0, v); check("R1 enable", v, 8'h00);
        rd(1'b1, v); check("R1 flags", v, 8'h00);
        check("R1 irq_src", {5'd0, irq_src}, 8'h00);
        check("R1 irq_any", {7'd0, irq_any}, 8'h00);

        // R2: enable register sweep with junk in reserved bits
        for (int m = 0; m < 8; m++) begin
            wr(1'b0, {5'b10110, 3'(m)});
            rd(1'b0, v); check("R2 enable readback", v, 8'(m));
        end

        // R3: each event pattern sets exactly its flags; others preserved
        for (int p = 0; p < 8; p++) begin
            load_flags(3'(p));
            rd(1'b1, v); check("R3 event sets", v, 8'(p));
        end
        load_flags(3'b001);
        evt = 3'b100; tick(); evt = '0;
        rd(1'b1, v); check("R3 keeps other flags", v, 8'h05);
        tick();
        rd(1'b1, v); check("R3 no set without event", v, 8'h05);

        // R4: write-one-to-clear, every start state and write pattern
        for (int f = 0; f < 8; f++) begin
            for (int w = 0; w < 8; w++) begin
                load_flags(3'(f));
                wr(1'b1, {5'b11001, 3'(w)});
                rd(1'b1, v); check("R4 w1c", v, 8'(f & ~w & 7));
            end
        end

        // R5: acknowledge clears only the indexed flag; index 3 clears none
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < 4; i++) begin
                load_flags(3'(f));
                ack_valid = 1'b1; ack_idx = 2'(i);
                tick();
                ack_valid = 1'b0;
                rd(1'b1, v);
                check("R5 ack", v, 8'(f & ~((i < 3) ? (1 << i) : 0) & 7));
            end
            load_flags(3'(f));
            ack_idx = 2'd0;
            tick();
            rd(1'b1, v); check("R5 idx without valid", v, 8'(f));
        end

        // R6: set wins over simultaneous write-clear and acknowledge
        for (int i = 0; i < 3; i++) begin
            load_flags(3'b000);
            evt = 3'(1 << i);
            ack_valid = 1'b1; ack_idx = 2'(i);
            reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'hFF;
            tick();
            evt = '0; ack_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
            rd(1'b1, v); check("R6 set wins", v, 8'(1 << i));
        end

        // R7/R8: request gating and registered combine, full sweep
        for (int m = 0; m < 8; m++) begin
            for (int f = 0; f < 8; f++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [2:0] exp;
                    wr(1'b0, 8'(m));
                    load_flags(3'(f));
                    gie = g[0];
                    exp = 3'(m & f & (g ? 7 : 0));
                    #1;
                    check("R7 irq_src", {5'd0, irq_src}, {5'd0, exp});
                    tick();
                    check("R8 irq_any", {7'd0, irq_any}, {7'd0, |exp});
                end
            end
        end

        // R1: reset in mid-run
        wr(1'b0, 8'h07); load_flags(3'b111); gie = 1'b1;
        rst = 1'b1; tick(); rst = 1'b0;
        rd(1'b0, v); check("R1 mid-run enable", v, 8'h00);
        rd(1'b1, v); check("R1 mid-run flags", v, 8'h00);
        check("R1 mid-run irq_any", {7'd0, irq_any}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule